// File: doc/BRIEF.md
# Thermometer-to-Binary Multiplexer-Tree Decoder

This block turns a thermometer word of 2^N−1 bits into an N-bit binary count by binary search. A legal thermometer word is a run of ones that starts at bit 0 and has no gaps. The most significant output bit is the middle thermometer bit. That bit also steers a rank of 2-to-1 multiplexers, which pass the upper half of the word (the bits above the middle) when it is 1 and the lower half when it is 0. Each following level repeats the same step on a half-size word and yields the next bit. The last level reads a single remaining bit as the LSB.

The datapath itself has no state. Two parameters place an optional register in front of the tree and an optional register behind it. The latency is therefore zero, one or two clock cycles. Both registers clear asynchronously when reset is low. The block is meant to sit behind a bank of comparators, in cases where the depth of an adder-based ones counter is too large for the sampling rate.

Top module: `thermoMuxDecoder`

## Requirements
- R1: For every legal thermometer word (ones in bits 0 up to c−1 and zeros above, c from 0 to 2^N−1), the output equals c, the number of ones.
- R2: Output bit N−1 equals thermometer bit 2^(N−1)−1, the middle bit of the word.
- R3: For any word, legal or not, the output follows the binary search. If the current middle bit is 1, the next level works on the bits above it; otherwise it works on the bits below it. Each level sets one output bit, from MSB to LSB.
- R4: An all-zero word gives output 0.
- R5: An all-ones word gives output 2^N−1.
- R6: The output reflects the input after IN_REG+OUT_REG clock cycles, with each enabled register adding exactly one cycle. With both registers disabled, the block is purely combinational.
- R7: While rstN is low, every configuration that has at least one register drives an output of 0, whatever the input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional stage registers |
| rstN | input | 1 | Asynchronous active-low reset of the stage registers |
| thermoIn | input | 2^N−1 | Thermometer word; bit 0 is the lowest threshold |
| binOut | output | N | Binary result, MSB decided by the first tree level |

## Verification
Legal codes never reveal which half a level has discarded, because in a clean word the discarded half is all ones or all zeros. The case that is hardest to reach is therefore a word with bubbles, where a wrong half-select shows up only in the lower bits. After a full sweep of every legal code at four values of N, the stimulus drives a long run of pseudo-random words. The bench compares each of these words against a behavioural binary search, so every level's steering is exercised on both sides with a mixed half.

// File: rtl/thermoMuxPkg.sv
package thermoMuxPkg;

  // Width of the word handled by tree level k of an n-bit decoder.
  function automatic int levelWidth(input int n, input int k);
    return (1 << (n - k)) - 1;
  endfunction

  // Bit offset of level k inside the flattened level chain.
  function automatic int levelOffset(input int n, input int k);
    int sum;
    sum = 0;
    for (int j = 0; j < k; j++) sum += levelWidth(n, j);
    return sum;
  endfunction

  // Total bits carried by all levels together.
  function automatic int chainWidth(input int n);
    return levelOffset(n, n);
  endfunction

endpackage

// File: rtl/thermoStageReg.sv
module thermoStageReg #(
  parameter int W  = 1,
  parameter bit EN = 1'b1
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  generate
    if (EN) begin : g_reg
      logic [W-1:0] held;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) held <= '0;
        else       held <= d;
      end
      assign q = held;
    end else begin : g_wire
      assign q = d;
    end
  endgenerate

endmodule

// File: rtl/thermoMuxLevel.sv
module thermoMuxLevel #(
  parameter int W = 3
) (
  input  logic [W-1:0]       vecIn,
  output logic               bitOut,
  output logic [(W-1)/2-1:0] vecOut
);

  localparam int HALF = (W - 1) / 2;
  localparam int MID  = HALF;

  // Middle bit settles this level's output bit and picks the half kept.
  assign bitOut = vecIn[MID];
  assign vecOut = bitOut ? vecIn[W-1:MID+1] : vecIn[MID-1:0];

endmodule

// File: rtl/thermoMuxTree.sv
module thermoMuxTree #(
  parameter int N = 4
) (
  input  logic [(1<<N)-2:0] thermo,
  output logic [N-1:0]      bin
);

  import thermoMuxPkg::*;

  localparam int TW   = (1 << N) - 1;
  localparam int TOTW = chainWidth(N);
  localparam int LAST = levelOffset(N, N - 1);

  logic [TOTW-1:0] chain;

  assign chain[0 +: TW] = thermo;

  generate
    for (genvar k = 0; k < N - 1; k++) begin : g_level
      localparam int WK = levelWidth(N, k);
      localparam int WN = levelWidth(N, k + 1);
      localparam int OK = levelOffset(N, k);
      localparam int ON = levelOffset(N, k + 1);
      thermoMuxLevel #(.W(WK)) u_level (
        .vecIn (chain[OK +: WK]),
        .bitOut(bin[N-1-k]),
        .vecOut(chain[ON +: WN])
      );
    end
  endgenerate

  // The final level holds a single bit, which is the LSB.
  assign bin[0] = chain[LAST];

endmodule

// File: rtl/thermoMuxDecoder.sv
module thermoMuxDecoder #(
  parameter int N       = 4,
  parameter bit IN_REG  = 1'b1,
  parameter bit OUT_REG = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [(1<<N)-2:0] thermoIn,
  output logic [N-1:0]      binOut
);

  localparam int TW = (1 << N) - 1;

  logic [TW-1:0] thermoStaged;
  logic [N-1:0]  binComb;

  thermoStageReg #(.W(TW), .EN(IN_REG)) u_inStage (
    .clk (clk),
    .rstN(rstN),
    .d   (thermoIn),
    .q   (thermoStaged)
  );

  thermoMuxTree #(.N(N)) u_tree (
    .thermo(thermoStaged),
    .bin   (binComb)
  );

  thermoStageReg #(.W(N), .EN(OUT_REG)) u_outStage (
    .clk (clk),
    .rstN(rstN),
    .d   (binComb),
    .q   (binOut)
  );

endmodule

// File: rtl/thermoMuxDecoderChecker.sv
module thermoMuxDecoderChecker #(
  parameter int N       = 4,
  parameter bit IN_REG  = 1'b1,
  parameter bit OUT_REG = 1'b1
) (
  input logic              clk,
  input logic              rstN,
  input logic [(1<<N)-2:0] thermoIn,
  input logic [N-1:0]      binOut
);

  localparam int TW  = (1 << N) - 1;
  localparam int LAT = int'(IN_REG) + int'(OUT_REG);
  localparam int MID = (1 << (N - 1)) - 1;

  // Input history aligned with the output; cleared like the design registers.
  logic [TW-1:0] hist [LAT+1];
  logic [TW:0]   histWide;
  logic          histLegal;

  always_comb hist[0] = thermoIn;

  generate
    for (genvar i = 1; i <= LAT; i++) begin : g_hist
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) hist[i] <= '0;
        else       hist[i] <= hist[i-1];
      end
    end
  endgenerate

  assign histWide  = {1'b0, hist[LAT]};
  assign histLegal = ((histWide & (histWide + 1'b1)) == '0);

  // R1 and R6: a legal word, seen LAT cycles later, decodes to its ones count.
  a_r1_count: assert property (@(posedge clk) disable iff (!rstN)
    histLegal |-> (int'(binOut) == $countones(hist[LAT])));

  a_r2_msb: assert property (@(posedge clk) disable iff (!rstN)
    binOut[N-1] == hist[LAT][MID]);

  a_r4_zero: assert property (@(posedge clk) disable iff (!rstN)
    (hist[LAT] == '0) |-> (binOut == '0));

  a_r5_full: assert property (@(posedge clk) disable iff (!rstN)
    (&hist[LAT]) |-> (&binOut));

  generate
    if (LAT > 0) begin : g_rst
      a_r7_reset: assert property (@(negedge clk) !rstN |-> (binOut == '0));
    end
  endgenerate

endmodule

bind thermoMuxDecoder thermoMuxDecoderChecker #(
  .N(N), .IN_REG(IN_REG), .OUT_REG(OUT_REG)
) u_chk (
  .clk(clk), .rstN(rstN), .thermoIn(thermoIn), .binOut(binOut)
);

// File: tb/thermoMuxDecoder_bench.sv
module thermoMuxDecoder_bench;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [6:0]  t3;
  logic [14:0] t4;
  logic [30:0] t5;
  logic [62:0] t6;
  logic [2:0]  b3;
  logic [3:0]  b4;
  logic [4:0]  b5;
  logic [5:0]  b6;

  // Main instance: N=4, both registers (latency 2).
  thermoMuxDecoder #(.N(4), .IN_REG(1'b1), .OUT_REG(1'b1)) u_thermoMuxDecoder (
    .clk(clk), .rstN(rstN), .thermoIn(t4), .binOut(b4));
  thermoMuxDecoder #(.N(3), .IN_REG(1'b0), .OUT_REG(1'b0)) u_n3 (
    .clk(clk), .rstN(rstN), .thermoIn(t3), .binOut(b3));
  thermoMuxDecoder #(.N(5), .IN_REG(1'b1), .OUT_REG(1'b0)) u_n5 (
    .clk(clk), .rstN(rstN), .thermoIn(t5), .binOut(b5));
  thermoMuxDecoder #(.N(6), .IN_REG(1'b0), .OUT_REG(1'b1)) u_n6 (
    .clk(clk), .rstN(rstN), .thermoIn(t6), .binOut(b6));

  int checks = 0;
  int fails  = 0;
  logic [62:0] q3[$], q4[$], q5[$], q6[$];

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, got, exp);
    end
  endtask

  // Behavioural binary search over word positions.
  function automatic int refDecode(input int n, input logic [62:0] w);
    int base, res, span, mid;
    base = 0;
    res  = 0;
    for (int k = 0; k < n; k++) begin
      span = 1 << (n - k);
      mid  = base + span / 2 - 1;
      if (w[mid]) begin
        res  = res | (1 << (n - 1 - k));
        base = mid + 1;
      end
    end
    return res;
  endfunction

  task automatic evalOut(input string who, input int n, input logic [62:0] w,
                         input logic [7:0] got);
    int full, ones;
    logic [63:0] ww;
    bit legal;
    full  = (1 << n) - 1;
    ones  = $countones(w);
    ww    = {1'b0, w};
    legal = ((ww & (ww + 64'd1)) == 64'd0);
    if (w == '0)          check({who, " R4 all-zero"}, 64'(got), 64'd0);
    else if (ones == full) check({who, " R5 all-ones"}, 64'(got), 64'(full));
    else if (legal)       check({who, " R1 legal count"}, 64'(got), 64'(ones));
    else                  check({who, " R3 bubbly search"}, 64'(got), 64'(refDecode(n, w)));
    check({who, " R2 msb"}, 64'(got[n-1]), 64'(w[(1 << (n - 1)) - 1]));
  endtask

  function automatic logic [62:0] legalWord(input int n, input int cyc);
    int c;
    c = cyc % (1 << n);
    return 63'((64'd1 << c) - 64'd1);
  endfunction

  task automatic finishRun();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    logic [63:0] lfsr;
    logic [62:0] w3, w4, w5, w6;
    lfsr = 64'h9E37_79B9_7F4A_7C15;
    t3 = '1; t4 = '1; t5 = '1; t6 = '1;
    repeat (3) @(negedge clk);
    // R7: registered configurations hold zero during reset.
    check("u_thermoMuxDecoder R7 reset", 64'(b4), 64'd0);
    check("u_n5 R7 reset", 64'(b5), 64'd0);
    check("u_n6 R7 reset", 64'(b6), 64'd0);
    t3 = '0; t4 = '0; t5 = '0; t6 = '0;
    rstN = 1'b1;
    for (int i = 0; i < 3; i++) begin
      q3.push_back('0); q4.push_back('0); q5.push_back('0); q6.push_back('0);
    end
    for (int cyc = 0; cyc < 600; cyc++) begin
      @(negedge clk);
      if (cyc < 64) begin
        w3 = legalWord(3, cyc); w4 = legalWord(4, cyc);
        w5 = legalWord(5, cyc); w6 = legalWord(6, cyc);
      end else begin
        lfsr = lfsr ^ (lfsr << 13);
        lfsr = lfsr ^ (lfsr >> 7);
        lfsr = lfsr ^ (lfsr << 17);
        w3 = {56'd0, lfsr[6:0]};
        w4 = {48'd0, lfsr[22:8]};
        w5 = {32'd0, lfsr[62:32]};
        w6 = lfsr[63:1] ^ {lfsr[30:0], lfsr[63:32]};
      end
      t3 = w3[6:0]; t4 = w4[14:0]; t5 = w5[30:0]; t6 = w6;
      q3.push_back(w3); q4.push_back(w4); q5.push_back(w5); q6.push_back(w6);
      #1;
      // R6: each instance is compared against the word from its latency ago.
      evalOut("u_thermoMuxDecoder R6 lat2", 4, q4[q4.size()-3], 8'(b4));
      evalOut("u_n3 R6 lat0", 3, q3[q3.size()-1], 8'(b3));
      evalOut("u_n5 R6 lat1", 5, q5[q5.size()-2], 8'(b5));
      evalOut("u_n6 R6 lat1", 6, q6[q6.size()-2], 8'(b6));
    end
    finishRun();
  end

endmodule